// File: doc/BRIEF.md
# Monochrome-to-Color Expansion Unit

This block turns a monochrome bitmap streamed in by a host into destination pixel bytes for a system-to-screen block transfer. Each source bit chooses between a latched foreground and background color. The bit also becomes the write-enable for the pixel bytes it produces, so clear bits can be left transparent by the memory writer downstream. Pixels are either one byte wide or two bytes wide. In the two-byte mode every source bit produces the low color byte and then the high color byte.

The host loads the colors, the pixel-width mode, the row width and the row count with a one-cycle start pulse. It then pushes 8-, 16- or 32-bit words through a valid/ready handshake. The unit splits each word into bytes, starting with the least significant byte, and shifts each byte out from its most significant bit. It presents one destination byte per cycle on a second valid/ready handshake. A row-end flag marks the last byte of each row, where the destination address moves on to the next row. Bits left over in the current source byte at a row end are dropped. The transfer ends after the byte that takes the row counter past zero.

Top module: `color_expand`

## Requirements
- R1: After reset `busy`, `out_valid` and `in_ready` are low.
- R2: Source bits are used most significant bit first. A 1 selects the foreground color and a 0 selects the background color. `out_we` equals the bit in use.
- R3: With `px16` = 0, every emitted byte is the low byte of the selected color and uses up one source bit.
- R4: With `px16` = 1, bytes alternate within a row. The first byte of the pair is the low color byte and does not use up the bit. The second byte is the high color byte, and the next bit is taken after it.
- R5: `in_size` encodes the host word width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. A word is split into that many bytes, starting with the least significant byte, and the bytes are expanded in that order.
- R6: `width` holds the number of bytes per row minus one. `out_row_end` is high on the last byte of every row. The column count then reloads, any unused bits of the current source byte are discarded, and the next row starts on a fresh source byte.
- R7: `height` holds the number of rows minus one. A start pulse while idle sets `busy`. `busy` falls right after the last byte of the row that decrements the row counter past zero. After that, `in_ready` and `out_valid` stay low.
- R8: A start pulse while `busy` is ignored. The colors, mode and counts of the running transfer are unchanged, and the color inputs may change freely after start.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte`, `out_we` and `out_row_end` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, latches configuration when idle |
| fg_color | input | 16 | Foreground color |
| bg_color | input | 16 | Background color |
| px16 | input | 1 | 1 = two-byte pixels |
| width | input | CNT_W | Bytes per row minus one |
| height | input | CNT_W | Rows minus one |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Host word accepted |
| in_data | input | HOST_W | Host word, least significant byte used first |
| in_size | input | 2 | Host word width code |
| out_valid | output | 1 | Destination byte valid |
| out_ready | input | 1 | Destination byte taken |
| out_byte | output | 8 | Destination pixel byte |
| out_we | output | 1 | Byte write-enable (source bit) |
| out_row_end | output | 1 | Last byte of the current row |
| busy | output | 1 | Transfer in progress |

## Verification
Two things can happen in the same cycle: the host word handshake, and the emission of a row's last byte, which discards the partly used source byte. The accepted word has to survive that discard and supply the next row. The bench provokes this by keeping host words pending, with random gaps, while the output side is randomly back-pressured. Row widths that are not multiples of eight make discards frequent. Each emitted byte is compared against a bench model that rebuilds the row-by-row bit consumption from the source bytes. A word lost or reordered at a row boundary therefore shows up as a byte mismatch in the following row.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

    localparam int COLOR_W = 16;
    localparam int PIX_W   = 8;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_32B = 2'd3
    } host_size_e;

    typedef struct packed {
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        logic               px16;
    } color_cfg_t;

    function automatic logic [3:0] size_bytes(host_size_e s);
        case (s)
            SZ_8:    return 4'd1;
            SZ_16:   return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/cexp_splitter.sv
module cexp_splitter
    import cexp_pkg::*;
#(
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HOST_W-1:0] in_data,
    input  logic [1:0]        in_size,
    output logic              byte_valid,
    output logic [PIX_W-1:0]  byte_data,
    input  logic              byte_take
);
    localparam int NB = HOST_W / 8;
    localparam int CW = $clog2(NB + 1);
    localparam logic [3:0] NB4 = 4'(NB);

    logic [HOST_W-1:0] buf_q;
    logic [CW-1:0]     left_q;
    logic [3:0]        req_n;
    logic [3:0]        take_n;

    assign req_n      = size_bytes(host_size_e'(in_size));
    assign take_n     = (req_n > NB4) ? NB4 : req_n;
    assign in_ready   = active && (left_q == '0);
    assign byte_valid = (left_q != '0);
    assign byte_data  = buf_q[PIX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            left_q <= '0;
        end else if (in_valid && in_ready) begin
            buf_q  <= in_data;
            left_q <= CW'(take_n);
        end else if (byte_take && byte_valid) begin
            buf_q  <= buf_q >> PIX_W;
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/cexp_pixel.sv
module cexp_pixel
    import cexp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             load,
    input  color_cfg_t       cfg,
    input  logic             byte_valid,
    input  logic [PIX_W-1:0] byte_data,
    output logic             byte_take,
    input  logic             fire,
    input  logic             row_end,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_byte,
    output logic             out_we
);
    color_cfg_t         cfg_q;
    logic [PIX_W-1:0]   sbyte_q;
    logic [3:0]         sbits_q;
    logic               hi_q;
    logic               cur_bit;
    logic [COLOR_W-1:0] color;

    assign cur_bit   = sbyte_q[PIX_W-1];
    assign color     = cur_bit ? cfg_q.fg : cfg_q.bg;
    assign out_byte  = (cfg_q.px16 && hi_q) ? color[COLOR_W-1:PIX_W] : color[PIX_W-1:0];
    assign out_we    = cur_bit;
    assign out_valid = active && (sbits_q != 4'd0);
    assign byte_take = active && (sbits_q == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            sbyte_q <= '0;
            sbits_q <= 4'd0;
            hi_q    <= 1'b0;
        end else if (load) begin
            cfg_q   <= cfg;
            sbits_q <= 4'd0;
            hi_q    <= 1'b0;
        end else if (fire) begin
            if (row_end) begin
                sbits_q <= 4'd0;
                hi_q    <= 1'b0;
            end else if (cfg_q.px16 && !hi_q) begin
                hi_q    <= 1'b1;
            end else begin
                hi_q    <= 1'b0;
                sbyte_q <= sbyte_q << 1;
                sbits_q <= sbits_q - 4'd1;
            end
        end else if (byte_take && byte_valid) begin
            sbyte_q <= byte_data;
            sbits_q <= 4'(PIX_W);
        end
    end
endmodule

// File: rtl/cexp_raster.sv
module cexp_raster #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] height,
    input  logic             fire,
    output logic             load,
    output logic             busy,
    output logic             row_end,
    output logic             finish
);
    logic [CNT_W-1:0] col_q;
    logic [CNT_W-1:0] wid_q;
    logic [CNT_W-1:0] row_q;
    logic [CNT_W-1:0] row_nx;
    logic             busy_q;

    assign busy    = busy_q;
    assign load    = start && !busy_q;
    assign row_end = (col_q == '0);
    assign row_nx  = row_q - 1'b1;
    assign finish  = fire && row_end && (row_nx == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            col_q  <= '0;
            wid_q  <= '0;
            row_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            col_q  <= width;
            wid_q  <= width;
            row_q  <= height;
        end else if (fire) begin
            if (row_end) begin
                col_q <= wid_q;
                row_q <= row_nx;
                if (row_nx == '1) busy_q <= 1'b0;
            end else begin
                col_q <= col_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/color_expand.sv
module color_expand
    import cexp_pkg::*;
#(
    parameter int HOST_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COLOR_W-1:0] fg_color,
    input  logic [COLOR_W-1:0] bg_color,
    input  logic               px16,
    input  logic [CNT_W-1:0]   width,
    input  logic [CNT_W-1:0]   height,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [HOST_W-1:0]  in_data,
    input  logic [1:0]         in_size,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_byte,
    output logic               out_we,
    output logic               out_row_end,
    output logic               busy
);
    logic             load, row_end, finish, fire;
    logic             byte_valid, byte_take;
    logic [PIX_W-1:0] byte_data;
    color_cfg_t       cfg_in;

    assign cfg_in      = '{fg: fg_color, bg: bg_color, px16: px16};
    assign fire        = out_valid && out_ready;
    assign out_row_end = out_valid && row_end;

    cexp_raster #(.CNT_W(CNT_W)) u_raster (
        .clk(clk), .rst(rst), .start(start), .width(width), .height(height),
        .fire(fire), .load(load), .busy(busy), .row_end(row_end), .finish(finish)
    );

    cexp_splitter #(.HOST_W(HOST_W)) u_split (
        .clk(clk), .rst(rst), .active(busy), .flush(finish),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_size(in_size),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take)
    );

    cexp_pixel u_pixel (
        .clk(clk), .rst(rst), .active(busy), .load(load), .cfg(cfg_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_take(byte_take),
        .fire(fire), .row_end(row_end),
        .out_valid(out_valid), .out_byte(out_byte), .out_we(out_we)
    );
endmodule

// File: rtl/cexp_chk.sv
module cexp_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_we,
    input logic       out_row_end
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !in_ready)) else $error("idle outputs active"); // R7

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy) else $error("start did not launch"); // R7

    AST_FINISH_ON_ROW_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(out_valid && out_ready && out_row_end)) else $error("busy fell early"); // R7

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_we) && $stable(out_row_end)))
        else $error("output changed under back-pressure"); // R9

    AST_STALL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !(out_valid && out_ready)) |=> busy) else $error("busy dropped without emission"); // R8
endmodule

bind color_expand cexp_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_we(out_we), .out_row_end(out_row_end)
);

// File: tb/tb_color_expand.sv
`timescale 1ns/1ps
module tb_color_expand;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] fg_color, bg_color;
    logic        px16;
    logic [15:0] width, height;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic [1:0]  in_size;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;
    logic        out_we;
    logic        out_row_end;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  exp_b[$];
    logic        exp_w[$];
    logic        exp_e[$];
    logic [31:0] hw_d[$];
    logic [1:0]  hw_s[$];

    always #5 clk = ~clk;

    color_expand dut (
        .clk(clk), .rst(rst), .start(start), .fg_color(fg_color), .bg_color(bg_color),
        .px16(px16), .width(width), .height(height), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_size(in_size),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_we(out_we), .out_row_end(out_row_end), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    task automatic host_drive(input bit gaps);
        while (hw_d.size() > 0) begin
            @(negedge clk);
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = hw_d[0];
                in_size  = hw_s[0];
                while (!in_ready) @(negedge clk);
                @(posedge clk);
                void'(hw_d.pop_front());
                void'(hw_s.pop_front());
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic sink(input bit restart_mid);
        int idx = 0;
        bit held = 0;
        logic [7:0] hb = 0;
        logic hw = 0, he = 0;
        int total = exp_b.size();
        while (idx < total) begin
            @(negedge clk);
            start = (restart_mid && idx == 3) ? 1'b1 : 1'b0;
            if (held) begin
                chk(out_valid && out_byte == hb && out_we == hw && out_row_end == he,
                    "R9", "held byte", int'(out_byte), int'(hb));
            end
            out_ready = ($urandom % 4) != 0;
            held = 1'b0;
            if (out_valid && out_ready) begin
                chk(out_byte == exp_b[idx], "R2/R3/R4/R5", "byte", int'(out_byte), int'(exp_b[idx]));
                chk(out_we == exp_w[idx], "R2", "we", int'(out_we), int'(exp_w[idx]));
                chk(out_row_end == exp_e[idx], "R6", "row_end", int'(out_row_end), int'(exp_e[idx]));
                idx++;
            end else if (out_valid) begin
                held = 1'b1; hb = out_byte; hw = out_we; he = out_row_end;
            end
        end
        @(negedge clk);
        start = 1'b0;
        out_ready = 1'b0;
    endtask

    // fsz < 0 picks a random host size per word
    task automatic run_blit(input logic [15:0] fg, input logic [15:0] bg, input bit p16,
                            input int wb, input int rows, input int fsz,
                            input bit gaps, input bit restart_mid);
        logic [7:0] src[$];
        int bits_row, bpr, total, idx, bitpos;
        bit hi;
        bits_row = p16 ? (wb + 1) / 2 : wb;
        bpr = (bits_row + 7) / 8;
        total = rows * bpr;
        for (int i = 0; i < total; i++) src.push_back(8'($urandom));
        idx = 0;
        while (idx < total) begin
            logic [1:0] s;
            logic [31:0] d;
            s = (fsz < 0) ? 2'($urandom % 4) : 2'(fsz);
            d = $urandom;
            for (int k = 0; k < 4; k++)
                if (k < nbytes(s) && idx + k < total) d[8*k +: 8] = src[idx + k];
            hw_d.push_back(d);
            hw_s.push_back(s);
            idx += nbytes(s);
        end
        for (int r = 0; r < rows; r++) begin
            bitpos = 0;
            hi = 0;
            for (int c = 0; c < wb; c++) begin
                logic b;
                logic [15:0] col;
                b = src[r * bpr + bitpos / 8][7 - (bitpos % 8)];
                col = b ? fg : bg;
                exp_b.push_back((p16 && hi) ? col[15:8] : col[7:0]);
                exp_w.push_back(b);
                exp_e.push_back(c == wb - 1);
                if (!p16 || hi) bitpos++;
                hi = p16 && !hi;
            end
        end
        @(negedge clk);
        fg_color = fg; bg_color = bg; px16 = p16;
        width = 16'(wb - 1); height = 16'(rows - 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fg_color = 16'($urandom); bg_color = 16'($urandom); px16 = ~p16;
        width = 16'($urandom); height = 16'($urandom);
        chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
        fork
            host_drive(gaps);
            sink(restart_mid);
        join
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after last byte", int'(busy), 0);
        chk(in_ready == 1'b0, "R7", "in_ready after finish", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R7", "out_valid after finish", int'(out_valid), 0);
        exp_b.delete(); exp_w.delete(); exp_e.delete();
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_data = '0; in_size = '0; fg_color = '0; bg_color = '0; px16 = 1'b0;
        width = '0; height = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R1", "out_valid reset", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R1", "in_ready reset", int'(in_ready), 0);
        // R3 R5: byte-wide pixels, 32-bit words split LSB first
        run_blit(16'h12AB, 16'h3400, 1'b0, 8, 2, 2, 1'b0, 1'b0);
        // R6: 5 bytes per row leaves 3 bits to discard
        run_blit(16'h00F0, 16'h000F, 1'b0, 5, 3, -1, 1'b1, 1'b0);
        // R4: two-byte pixels with 16-bit words
        run_blit(16'hBEEF, 16'h1234, 1'b1, 16, 2, 1, 1'b1, 1'b0);
        // R4 R5: two-byte pixels fed by 8-bit words
        run_blit(16'hA55A, 16'h0FF0, 1'b1, 6, 2, 0, 1'b0, 1'b0);
        // R6 R7: smallest transfer, one byte
        run_blit(16'h0077, 16'h0011, 1'b0, 1, 1, 0, 1'b0, 1'b0);
        // R8: restart while busy must be ignored
        run_blit(16'hC0DE, 16'h5151, 1'b1, 10, 3, -1, 1'b1, 1'b1);
        for (int t = 0; t < 20; t++)
            run_blit(16'($urandom), 16'($urandom), 1'($urandom), 1 + int'($urandom % 40),
                     1 + int'($urandom % 5), -1, 1'b1, 1'($urandom));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule